// File: doc/BRIEF.md
# AXI Read Command Width Translator (32-bit master to 64-bit slave)

This block joins a 32-bit AXI read master to a 64-bit AXI read slave. Each read address command is sorted, as it arrives, into one of three treatments. In translation mode, an INCR burst of 32-bit beats that starts on an 8-byte boundary and has an even beat count is packed. It goes out as a 64-bit burst of half the length, and every 64-bit beat that comes back is split into two 32-bit beats. Any other command is spread. It goes out with the same beat count at 64-bit size, and each returned 64-bit beat yields one 32-bit beat taken from the lane that the beat's own address selects. In pass-through mode every command and every data beat crosses unchanged.

The slave returns the beats of each burst together, in issue order. The block therefore keeps a small in-order queue that records how each outstanding burst must be unpacked. A spread command may go out only when no other burst is in flight. Packed and pass-through commands may overlap, up to a parameter limit. The read data port is 64 bits wide. In translation mode only its low 32 bits carry data.

Top module: `rd_upsizer`

## Requirements
- R1: In translation mode (`mode64`=0), a command with burst INCR (1), size 2, address bits [2:0] zero and an odd `s_arlen` (even beat count) is packed. It goes out with the same address and burst, size 3, and length (`s_arlen`+1)/2-1.
- R2: For a packed burst, each 64-bit beat produces two upstream beats: bits [31:0] first, then bits [63:32]. Each sits in `s_rdata[31:0]`.
- R3: In translation mode, every other command is spread: FIXED (0), WRAP (2), misaligned, odd beat count or a size other than 2. It goes out with the same address, burst and length, at size 3.
- R4: For a spread burst, each upstream beat takes bits [63:32] of the downstream beat when bit 2 of its 32-bit beat address is 1, and bits [31:0] otherwise. The beat address starts at the command address. It steps by 4 for INCR, stays put for FIXED and wraps inside a (len+1)*4-byte window for WRAP. In translation mode `s_rdata[63:32]` is zero.
- R5: While any burst is outstanding, a spread command is held: `s_arready` and `m_arvalid` stay low until the outstanding count reaches zero.
- R6: Packed and pass-through commands may issue while others are outstanding, but never when MAX_OUTS bursts are already in flight.
- R7: In pass-through mode (`mode64`=1), address, length, size (narrow sizes included) and burst go out unchanged. Data, response and last flag return unchanged.
- R8: Each upstream beat carries the response of the downstream beat it was taken from.
- R9: `s_rlast` is high only on the final 32-bit beat of the original command.
- R10: After reset, no command or data is presented and, with the slave ready, a command is accepted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode64 | input | 1 | 1 = pass-through, 0 = 32-bit translation |
| s_arvalid | input | 1 | Master command valid |
| s_arready | output | 1 | Master command ready |
| s_araddr | input | AW | Master command address |
| s_arlen | input | 8 | Master beats minus one |
| s_arsize | input | 3 | Master beat size code |
| s_arburst | input | 2 | Master burst type |
| s_rvalid | output | 1 | Master read data valid |
| s_rready | input | 1 | Master read data ready |
| s_rdata | output | 64 | Master read data |
| s_rresp | output | 2 | Master read response |
| s_rlast | output | 1 | Master final beat |
| m_arvalid | output | 1 | Slave command valid |
| m_arready | input | 1 | Slave command ready |
| m_araddr | output | AW | Slave command address |
| m_arlen | output | 8 | Slave beats minus one |
| m_arsize | output | 3 | Slave beat size code |
| m_arburst | output | 2 | Slave burst type |
| m_rvalid | input | 1 | Slave read data valid |
| m_rready | output | 1 | Slave read data ready |
| m_rdata | input | 64 | Slave read data |
| m_rresp | input | 2 | Slave read response |
| m_rlast | input | 1 | Slave final beat |

## Verification
The bench builds the block with MAX_OUTS at 2 and AW at 32. With that limit, two held packed bursts fill the queue and expose the outstanding cap. A single held burst is enough to show a spread command waiting. Spread commands use addresses whose bit 2 differs from beat to beat, including a WRAP that crosses its window, so every lane choice is exercised under an irregular upstream ready pattern.

// File: rtl/rdup_pkg.sv
`timescale 1ns/1ps
package rdup_pkg;
  localparam int PAGE_BITS = 12;

  localparam logic [1:0] BURST_FIXED = 2'd0;
  localparam logic [1:0] BURST_INCR  = 2'd1;
  localparam logic [1:0] BURST_WRAP  = 2'd2;
  localparam logic [2:0] SIZE_W32    = 3'd2;
  localparam logic [2:0] SIZE_W64    = 3'd3;

  typedef enum logic [1:0] {
    XL_PASS   = 2'd0,
    XL_PACK   = 2'd1,
    XL_SPREAD = 2'd2
  } xlate_e;

  typedef struct packed {
    xlate_e                 kind;
    logic [PAGE_BITS-1:0]   addr;
    logic [7:0]             len;
    logic [1:0]             burst;
  } track_t;

  // Packing needs INCR, 8-byte start, even beat count, 32-bit beats.
  function automatic logic packable(input logic [PAGE_BITS-1:0] addr,
                                    input logic [7:0] len,
                                    input logic [2:0] size,
                                    input logic [1:0] burst);
    return (burst == BURST_INCR) && (addr[2:0] == 3'b000) &&
           len[0] && (size == SIZE_W32);
  endfunction

  // Beat count halves: new len = (len+1)/2 - 1.
  function automatic logic [7:0] packed_len(input logic [7:0] len);
    logic [8:0] beats;
    beats = {1'b0, len} + 9'd1;
    return 8'((beats >> 1) - 9'd1);
  endfunction

  // Address of the next 32-bit beat inside a spread burst.
  function automatic logic [PAGE_BITS-1:0] step_addr(input logic [PAGE_BITS-1:0] addr,
                                                     input logic [7:0] len,
                                                     input logic [1:0] burst);
    logic [PAGE_BITS-1:0] inc;
    logic [PAGE_BITS-1:0] span_mask;
    inc       = addr + PAGE_BITS'(4);
    span_mask = PAGE_BITS'({len, 2'b11});
    case (burst)
      BURST_FIXED: return addr;
      BURST_WRAP:  return (addr & ~span_mask) | (inc & span_mask);
      default:     return inc;
    endcase
  endfunction
endpackage

// File: rtl/rdup_ar_xlate.sv
`timescale 1ns/1ps
module rdup_ar_xlate
  import rdup_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          mode64,
  input  logic [AW-1:0] in_addr,
  input  logic [7:0]    in_len,
  input  logic [2:0]    in_size,
  input  logic [1:0]    in_burst,
  output xlate_e        kind,
  output logic [AW-1:0] out_addr,
  output logic [7:0]    out_len,
  output logic [2:0]    out_size,
  output logic [1:0]    out_burst
);
  logic can_pack;

  assign can_pack = packable(in_addr[PAGE_BITS-1:0], in_len, in_size, in_burst);

  always_comb begin
    out_addr  = in_addr;
    out_burst = in_burst;
    if (mode64) begin
      kind     = XL_PASS;
      out_len  = in_len;
      out_size = in_size;
    end else if (can_pack) begin
      kind     = XL_PACK;
      out_len  = packed_len(in_len);
      out_size = SIZE_W64;
    end else begin
      kind     = XL_SPREAD;
      out_len  = in_len;
      out_size = SIZE_W64;
    end
  end
endmodule

// File: rtl/rdup_track_fifo.sv
`timescale 1ns/1ps
module rdup_track_fifo
  import rdup_pkg::*;
#(
  parameter  int DEPTH = 4,
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  track_t        push_item,
  input  logic          pop,
  output track_t        head,
  output logic          head_valid,
  output logic          full,
  output logic [CW-1:0] count
);
  track_t          slots [DEPTH];
  logic [PW-1:0]   wr_ptr;
  logic [PW-1:0]   rd_ptr;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign head       = slots[rd_ptr];
  assign head_valid = (count != '0);
  assign full       = (count == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (push) slots[wr_ptr] <= push_item;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rdup_r_unpack.sv
`timescale 1ns/1ps
module rdup_r_unpack
  import rdup_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  track_t      head,
  input  logic        head_valid,
  input  logic        m_rvalid,
  output logic        m_rready,
  input  logic [63:0] m_rdata,
  input  logic [1:0]  m_rresp,
  input  logic        m_rlast,
  output logic        s_rvalid,
  input  logic        s_rready,
  output logic [63:0] s_rdata,
  output logic [1:0]  s_rresp,
  output logic        s_rlast,
  output logic        burst_done
);
  logic                 hi_half;
  logic                 started;
  logic [PAGE_BITS-1:0] cur_addr;
  logic [PAGE_BITS-1:0] addr_now;
  logic                 up_fire;
  logic                 down_fire;

  assign addr_now = started ? cur_addr : head.addr;

  always_comb begin
    s_rvalid = head_valid && m_rvalid;
    s_rresp  = m_rresp;
    s_rdata  = '0;
    s_rlast  = 1'b0;
    m_rready = 1'b0;
    if (head_valid) begin
      case (head.kind)
        XL_PASS: begin
          s_rdata  = m_rdata;
          s_rlast  = m_rlast;
          m_rready = s_rready;
        end
        XL_PACK: begin
          s_rdata  = {32'h0, hi_half ? m_rdata[63:32] : m_rdata[31:0]};
          s_rlast  = m_rlast && hi_half;
          m_rready = s_rready && hi_half;
        end
        default: begin
          s_rdata  = {32'h0, addr_now[2] ? m_rdata[63:32] : m_rdata[31:0]};
          s_rlast  = m_rlast;
          m_rready = s_rready;
        end
      endcase
    end
  end

  assign up_fire    = s_rvalid && s_rready;
  assign down_fire  = head_valid && m_rvalid && m_rready;
  assign burst_done = down_fire && m_rlast;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_half  <= 1'b0;
      started  <= 1'b0;
      cur_addr <= '0;
    end else begin
      if (up_fire && head.kind == XL_PACK) hi_half <= ~hi_half;
      if (up_fire && head.kind == XL_SPREAD) begin
        cur_addr <= step_addr(addr_now, head.len, head.burst);
        started  <= 1'b1;
      end
      if (burst_done) started <= 1'b0;
    end
  end
endmodule

// File: rtl/rd_upsizer.sv
`timescale 1ns/1ps
module rd_upsizer
  import rdup_pkg::*;
#(
  parameter  int AW       = 32,
  parameter  int MAX_OUTS = 4,
  localparam int CW       = $clog2(MAX_OUTS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode64,
  input  logic          s_arvalid,
  output logic          s_arready,
  input  logic [AW-1:0] s_araddr,
  input  logic [7:0]    s_arlen,
  input  logic [2:0]    s_arsize,
  input  logic [1:0]    s_arburst,
  output logic          s_rvalid,
  input  logic          s_rready,
  output logic [63:0]   s_rdata,
  output logic [1:0]    s_rresp,
  output logic          s_rlast,
  output logic          m_arvalid,
  input  logic          m_arready,
  output logic [AW-1:0] m_araddr,
  output logic [7:0]    m_arlen,
  output logic [2:0]    m_arsize,
  output logic [1:0]    m_arburst,
  input  logic          m_rvalid,
  output logic          m_rready,
  input  logic [63:0]   m_rdata,
  input  logic [1:0]    m_rresp,
  input  logic          m_rlast
);
  xlate_e        ar_kind;
  logic          can_issue;
  logic          ar_fire;
  logic          q_full;
  logic [CW-1:0] outstanding;
  track_t        new_item;
  track_t        head_item;
  logic          head_valid;
  xlate_e        head_kind;
  logic          r_burst_done;

  rdup_ar_xlate #(.AW(AW)) u_xlate (
    .mode64    (mode64),
    .in_addr   (s_araddr),
    .in_len    (s_arlen),
    .in_size   (s_arsize),
    .in_burst  (s_arburst),
    .kind      (ar_kind),
    .out_addr  (m_araddr),
    .out_len   (m_arlen),
    .out_size  (m_arsize),
    .out_burst (m_arburst)
  );

  // Spread commands wait for an empty pipe; all wait for a free slot.
  assign can_issue = !q_full && ((ar_kind != XL_SPREAD) || (outstanding == '0));
  assign m_arvalid = s_arvalid && can_issue;
  assign s_arready = m_arready && can_issue;
  assign ar_fire   = m_arvalid && m_arready;

  assign new_item = '{kind:  ar_kind,
                      addr:  s_araddr[PAGE_BITS-1:0],
                      len:   s_arlen,
                      burst: s_arburst};

  rdup_track_fifo #(.DEPTH(MAX_OUTS)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (ar_fire),
    .push_item  (new_item),
    .pop        (r_burst_done),
    .head       (head_item),
    .head_valid (head_valid),
    .full       (q_full),
    .count      (outstanding)
  );

  assign head_kind = head_item.kind;

  rdup_r_unpack u_unpack (
    .clk        (clk),
    .rst_n      (rst_n),
    .head       (head_item),
    .head_valid (head_valid),
    .m_rvalid   (m_rvalid),
    .m_rready   (m_rready),
    .m_rdata    (m_rdata),
    .m_rresp    (m_rresp),
    .m_rlast    (m_rlast),
    .s_rvalid   (s_rvalid),
    .s_rready   (s_rready),
    .s_rdata    (s_rdata),
    .s_rresp    (s_rresp),
    .s_rlast    (s_rlast),
    .burst_done (r_burst_done)
  );
endmodule

// File: rtl/rdup_checker.sv
`timescale 1ns/1ps
module rdup_checker
  import rdup_pkg::*;
#(
  parameter  int MAX_OUTS = 4,
  localparam int CW       = $clog2(MAX_OUTS + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode64,
  input logic [7:0]    s_arlen,
  input logic [2:0]    s_arsize,
  input logic [1:0]    s_arburst,
  input logic          m_arvalid,
  input logic [7:0]    m_arlen,
  input logic [2:0]    m_arsize,
  input logic [1:0]    m_arburst,
  input logic          s_rvalid,
  input logic [63:0]   s_rdata,
  input logic          s_rlast,
  input logic          m_rvalid,
  input logic          m_rlast,
  input xlate_e        ar_kind,
  input xlate_e        head_kind,
  input logic [CW-1:0] outstanding
);
  assert_pack_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (m_arvalid && ar_kind == XL_PACK) |->
      ({m_arlen, 1'b1} == {1'b0, s_arlen}) && (m_arsize == SIZE_W64) && (m_arburst == s_arburst));

  assert_spread_fields_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (m_arvalid && ar_kind == XL_SPREAD) |-> (m_arlen == s_arlen) && (m_arsize == SIZE_W64));

  assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rvalid && head_kind != XL_PASS) |-> (s_rdata[63:32] == 32'h0));

  assert_spread_waits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (m_arvalid && ar_kind == XL_SPREAD) |-> (outstanding == '0));

  assert_outs_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    m_arvalid |-> (outstanding < CW'(MAX_OUTS)));

  assert_pass_fields_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_arvalid && mode64) |->
      (m_arlen == s_arlen) && (m_arsize == s_arsize) && (m_arburst == s_arburst));

  assert_last_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rvalid && s_rlast) |-> (m_rvalid && m_rlast));
endmodule

bind rd_upsizer rdup_checker #(.MAX_OUTS(MAX_OUTS)) u_rdup_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode64      (mode64),
  .s_arlen     (s_arlen),
  .s_arsize    (s_arsize),
  .s_arburst   (s_arburst),
  .m_arvalid   (m_arvalid),
  .m_arlen     (m_arlen),
  .m_arsize    (m_arsize),
  .m_arburst   (m_arburst),
  .s_rvalid    (s_rvalid),
  .s_rdata     (s_rdata),
  .s_rlast     (s_rlast),
  .m_rvalid    (m_rvalid),
  .m_rlast     (m_rlast),
  .ar_kind     (ar_kind),
  .head_kind   (head_kind),
  .outstanding (outstanding)
);

// File: tb/test_rd_upsizer.sv
`timescale 1ns/1ps
module test_rd_upsizer;
  localparam int AW       = 32;
  localparam int MAX_OUTS = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode64 = 1'b0;
  logic        s_arvalid = 1'b0;
  logic        s_arready;
  logic [31:0] s_araddr = '0;
  logic [7:0]  s_arlen = '0;
  logic [2:0]  s_arsize = 3'd2;
  logic [1:0]  s_arburst = 2'd1;
  logic        s_rvalid;
  logic        s_rready = 1'b1;
  logic [63:0] s_rdata;
  logic [1:0]  s_rresp;
  logic        s_rlast;
  logic        m_arvalid;
  logic        m_arready = 1'b1;
  logic [31:0] m_araddr;
  logic [7:0]  m_arlen;
  logic [2:0]  m_arsize;
  logic [1:0]  m_arburst;
  logic        m_rvalid = 1'b0;
  logic        m_rready;
  logic [63:0] m_rdata = '0;
  logic [1:0]  m_rresp = '0;
  logic        m_rlast = 1'b0;

  always #10 clk = ~clk;

  rd_upsizer #(.AW(AW), .MAX_OUTS(MAX_OUTS)) i_rd_upsizer (.*);

  typedef struct {
    logic [63:0] data;
    logic [1:0]  resp;
    logic        last;
    string       tag;
  } beat_t;

  typedef struct {
    logic [31:0] addr;
    logic [7:0]  len;
    logic [2:0]  size;
    logic [1:0]  burst;
    string       tag;
  } arx_t;

  beat_t      exp_beats[$];
  arx_t       exp_ar[$];
  logic [7:0] dn_len[$];
  int         checks = 0;
  int         errors = 0;
  int         cmd_no = 0;
  bit         slave_hold = 1'b0;
  bit         r_taken = 1'b0;
  bit         done = 1'b0;

  function automatic logic [31:0] lo_word(int c, int b);
    return {8'h4C, 8'(c), 8'(b), 8'h00};
  endfunction
  function automatic logic [31:0] hi_word(int c, int b);
    return {8'h48, 8'(c), 8'(b), 8'h11};
  endfunction
  function automatic logic [1:0] resp_of(int c, int b);
    return ((c + b) % 4 == 3) ? 2'b10 : 2'b00;
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: records the expected downstream command and upstream beats, then drives.
  task automatic send(logic [31:0] addr, logic [7:0] len, logic [2:0] size, logic [1:0] burst);
    arx_t  ea;
    beat_t eb;
    int    c = cmd_no;
    bit    pk;
    logic [31:0] a;
    cmd_no++;
    pk = (burst == 2'd1) && (addr[2:0] == 3'd0) && len[0] && (size == 3'd2);
    ea.addr = addr; ea.burst = burst;
    if (mode64) begin
      ea.len = len; ea.size = size; ea.tag = "R7 command";
      for (int b = 0; b <= int'(len); b++) begin
        eb.data = {hi_word(c, b), lo_word(c, b)}; eb.resp = resp_of(c, b);
        eb.last = (b == int'(len)); eb.tag = "R7"; exp_beats.push_back(eb);
      end
    end else if (pk) begin
      ea.len = 8'((int'(len) + 1) / 2 - 1); ea.size = 3'd3; ea.tag = "R1 command";
      for (int b = 0; b <= int'(ea.len); b++) begin
        for (int h = 0; h < 2; h++) begin
          eb.data = {32'h0, (h == 1) ? hi_word(c, b) : lo_word(c, b)};
          eb.resp = resp_of(c, b); eb.last = (b == int'(ea.len)) && (h == 1);
          eb.tag = "R2"; exp_beats.push_back(eb);
        end
      end
    end else begin
      ea.len = len; ea.size = 3'd3; ea.tag = "R3 command";
      a = addr;
      for (int b = 0; b <= int'(len); b++) begin
        eb.data = {32'h0, a[2] ? hi_word(c, b) : lo_word(c, b)};
        eb.resp = resp_of(c, b); eb.last = (b == int'(len)); eb.tag = "R4";
        exp_beats.push_back(eb);
        if (burst == 2'd1) a = a + 4;
        else if (burst == 2'd2) begin
          int w = (int'(len) + 1) * 4;
          a = (a & ~(w - 1)) | ((a + 4) & (w - 1));
        end
      end
    end
    exp_ar.push_back(ea);
    @(posedge clk); #1;
    s_arvalid = 1'b1; s_araddr = addr; s_arlen = len; s_arsize = size; s_arburst = burst;
    forever begin
      @(negedge clk);
      if (s_arready) begin
        @(posedge clk); #1;
        s_arvalid = 1'b0;
        break;
      end
    end
  endtask

  task automatic drain();
    while (exp_beats.size() != 0 || exp_ar.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
    #1;
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (m_arvalid && m_arready) begin
        arx_t ea;
        dn_len.push_back(m_arlen);
        if (exp_ar.size() == 0) check(1'b0, "R3 unexpected command", {m_araddr, m_arlen, 24'h0}, '0);
        else begin
          ea = exp_ar.pop_front();
          check(m_araddr == ea.addr && m_arlen == ea.len && m_arsize == ea.size && m_arburst == ea.burst,
                ea.tag, {m_araddr, m_arlen, 3'b0, m_arsize, 6'b0, m_arburst, 8'h0},
                {ea.addr, ea.len, 3'b0, ea.size, 6'b0, ea.burst, 8'h0});
        end
      end
      if (m_rvalid && m_rready) r_taken = 1'b1;
      if (s_rvalid && s_rready) begin
        beat_t eb;
        if (exp_beats.size() == 0) check(1'b0, "R9 unexpected beat", s_rdata, '0);
        else begin
          eb = exp_beats.pop_front();
          check(s_rdata == eb.data, eb.tag, s_rdata, eb.data);
          check(s_rresp == eb.resp, "R8 resp", 64'(s_rresp), 64'(eb.resp));
          check(s_rlast == eb.last, "R9 last", 64'(s_rlast), 64'(eb.last));
        end
      end
    end
  end

  // Slave model: beats of each burst in order, contiguous.
  initial begin
    int s_beat = 0;
    int s_cmd = 0;
    forever begin
      @(posedge clk); #1;
      if (r_taken) begin
        r_taken = 1'b0;
        if (s_beat == int'(dn_len[0])) begin
          void'(dn_len.pop_front()); s_cmd++; s_beat = 0;
        end else s_beat++;
      end
      if (!slave_hold && dn_len.size() != 0) begin
        m_rvalid = 1'b1;
        m_rdata  = {hi_word(s_cmd, s_beat), lo_word(s_cmd, s_beat)};
        m_rresp  = resp_of(s_cmd, s_beat);
        m_rlast  = (s_beat == int'(dn_len[0]));
      end else begin
        m_rvalid = 1'b0; m_rlast = 1'b0;
      end
    end
  end

  // Irregular upstream ready
  initial begin
    int n = 0;
    forever begin
      @(posedge clk); #1;
      s_rready = (n % 5) != 3;
      n++;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(!m_arvalid, "R10 m_arvalid", 64'(m_arvalid), 64'(0));
    check(!s_rvalid, "R10 s_rvalid", 64'(s_rvalid), 64'(0));
    check(s_arready, "R10 s_arready", 64'(s_arready), 64'(1));

    // R1 R2: packed bursts
    send(32'h0000_0100, 8'd3, 3'd2, 2'd1);
    send(32'h0000_0208, 8'd7, 3'd2, 2'd1);
    send(32'h0000_0010, 8'd1, 3'd2, 2'd1);
    drain();
    // R3 R4: spread bursts
    send(32'h0000_0104, 8'd3, 3'd2, 2'd1);
    send(32'h0000_0200, 8'd2, 3'd2, 2'd1);
    send(32'h0000_030C, 8'd2, 3'd2, 2'd0);
    send(32'h0000_0408, 8'd3, 3'd2, 2'd2);
    send(32'h0000_0500, 8'd3, 3'd1, 2'd1);
    drain();
    // R7: pass-through, narrow included
    mode64 = 1'b1;
    send(32'h0000_0600, 8'd3, 3'd3, 2'd1);
    send(32'h0000_0704, 8'd2, 3'd1, 2'd1);
    send(32'h0000_0808, 8'd3, 3'd3, 2'd2);
    drain();
    mode64 = 1'b0;

    // R5: spread command waits for the outstanding burst
    slave_hold = 1'b1;
    send(32'h0000_0900, 8'd3, 3'd2, 2'd1);
    fork
      send(32'h0000_0A04, 8'd1, 3'd2, 2'd1);
    join_none
    @(posedge clk); #2;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(!s_arready && !m_arvalid, "R5 spread held", {62'h0, s_arready, m_arvalid}, 64'h0);
    end
    @(posedge clk); #1 slave_hold = 1'b0;
    wait fork;
    drain();

    // R6: cap on outstanding bursts
    slave_hold = 1'b1;
    send(32'h0000_0B00, 8'd1, 3'd2, 2'd1);
    send(32'h0000_0B10, 8'd3, 3'd2, 2'd1);
    fork
      send(32'h0000_0B20, 8'd1, 3'd2, 2'd1);
    join_none
    @(posedge clk); #2;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(!s_arready && !m_arvalid, "R6 cap held", {62'h0, s_arready, m_arvalid}, 64'h0);
    end
    @(posedge clk); #1 slave_hold = 1'b0;
    wait fork;
    drain();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule